// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked system use an external asynchronous static RAM of 1M words by 8 bits. The RAM has three active-low strobes: chip enable, output enable and write enable. A user issues one access at a time through a request/ready handshake that carries an address, write data and a write flag. Each access is acknowledged by a one-cycle response pulse, and for reads that pulse carries the returned byte.

The RAM has no clock, so its timing limits are given in nanoseconds. The controller takes the clock period and those limits as parameters. It rounds each limit up to a whole number of clock cycles and never uses fewer than one cycle. Writes keep output enable high for their whole length, which allows the shorter write-enable pulse. The data drivers turn on only after the RAM has had time to release the bus, and they stay on one cycle past the rise of write enable. Between accesses the RAM is deselected, which puts it in standby.

The data bus appears as three signals: an output value, a drive enable for the pad and the value read back from the pad.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, and whenever no access is running, chip enable, output enable and write enable are all high (1), the data drivers are off and reqReady is 1.
- R2: A request is accepted only at a clock edge where reqValid and reqReady are both 1. reqReady is 0 for the whole of an access. reqValid raised during an access has no effect: the memory address does not change, no extra response is produced and the memory is not written.
- R3: A read holds chip enable and output enable low with write enable high for exactly RD_CYC cycles. With the default parameters this is 3 cycles.
- R4: The read byte is sampled from the bus on the last cycle of the read. rspValid is high for exactly one cycle, the same cycle in which output enable returns high, and rspRdata carries the sampled byte in that cycle.
- R5: A write keeps output enable high throughout. It starts with TURN_CYC cycles (default 1) in which chip enable is low, write enable is high and the drivers are off.
- R6: Write enable is then low for exactly PULSE_CYC cycles (default 2). The drivers are on for that whole time, with the request's write data on the bus.
- R7: The drivers stay on for one more cycle after write enable rises. They turn off at the same edge at which chip enable returns high and rspValid pulses for one cycle.
- R8: Each cycle count is the nanosecond limit divided by CLK_NS and rounded up, with a minimum of 1. With CLK_NS = 4, a 10 ns read limit gives 3 cycles, a 4 ns release limit gives 1 cycle and an 8 ns pulse limit gives 2 cycles.
- R9: The memory address is stable for as long as chip enable is low. It equals the accepted request's address.
- R10: Responses come back in request order, with exactly one response per accepted request. A read returns the byte most recently written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle; a request is accepted at the next edge |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| rspValid | output | 1 | One-cycle completion pulse |
| rspRdata | output | DATA_W | Read data, valid with rspValid after a read |
| memAddr | output | ADDR_W | Memory address |
| memCeN | output | 1 | Chip enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memDqOut | output | DATA_W | Value for the data pads |
| memDqOe | output | 1 | Pad drive enable, 1 = drive |
| memDqIn | input | DATA_W | Value seen on the data pads |

## Verification
The properties assume that reqAddr, reqWdata and reqWrite are held stable from the edge where the request is accepted. They also assume that memDqIn matters only while the RAM is driving, that is, while chip enable and output enable are low and write enable is high. The bench keeps to this. It changes request fields only on falling clock edges, presents a request only when reqReady is seen high, and drops reqValid one cycle after acceptance, except in the test that deliberately holds reqValid during a busy read. Its RAM model drives the bus only in the read combination of the three strobes. It commits a write at the moment the chip-enable/write-enable overlap ends, using the data captured in the last overlapped cycle.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WTURN,
    ST_WPULSE,
    ST_WEND
  } ctrlState_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadReq;
    logic captureRd;
  } dpStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // ns limit -> clock cycles, rounded up; any non-zero limit costs a cycle
  function automatic int cyclesFor(input int limitNs, input int clkNs);
    if (limitNs <= 0) return 0;
    return maxOf(1, (limitNs + clkNs - 1) / clkNs);
  endfunction

endpackage

// File: rtl/asram_datapath.sv
module asram_datapath
  import asram_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic [DATA_W-1:0] rspRdata
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr  <= '0;
      memDqOut <= '0;
    end else if (strobe.loadReq) begin
      memAddr  <= reqAddr;
      memDqOut <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspRdata <= '0;
    end else if (strobe.captureRd) begin
      rspRdata <= memDqIn;
    end
  end

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int RD_CYC    = 3,
  parameter int TURN_CYC  = 1,
  parameter int PULSE_CYC = 2,
  parameter int CNT_W     = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  output logic      reqReady,
  output dpStrobe_t strobe,
  output logic      memCeN,
  output logic      memOeN,
  output logic      memWeN,
  output logic      memDqOe,
  output logic      rspValid
);

  localparam logic [CNT_W-1:0] RD_LOAD    = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LOAD  = CNT_W'(TURN_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LOAD = CNT_W'(PULSE_CYC - 1);

  ctrlState_t       state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic             lastCyc;

  assign lastCyc  = (cnt == '0);
  assign reqReady = (state == ST_IDLE);

  always_comb begin
    stateNext = state;
    cntNext   = lastCyc ? cnt : cnt - 1'b1;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          if (reqWrite) begin
            stateNext = ST_WTURN;
            cntNext   = TURN_LOAD;
          end else begin
            stateNext = ST_READ;
            cntNext   = RD_LOAD;
          end
        end
      end
      ST_READ:   if (lastCyc) stateNext = ST_IDLE;
      ST_WTURN: begin
        if (lastCyc) begin
          stateNext = ST_WPULSE;
          cntNext   = PULSE_LOAD;
        end
      end
      ST_WPULSE: if (lastCyc) stateNext = ST_WEND;
      ST_WEND:   stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe           = '0;
    strobe.loadReq   = (state == ST_IDLE) && reqValid;
    strobe.captureRd = (state == ST_READ) && lastCyc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  // memory strobes registered from the next state: no decode glitches at pins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memCeN   <= 1'b1;
      memOeN   <= 1'b1;
      memWeN   <= 1'b1;
      memDqOe  <= 1'b0;
      rspValid <= 1'b0;
    end else begin
      memCeN   <= (stateNext == ST_IDLE);
      memOeN   <= (stateNext != ST_READ);
      memWeN   <= (stateNext != ST_WPULSE);
      memDqOe  <= (stateNext == ST_WPULSE) || (stateNext == ST_WEND);
      rspValid <= ((state == ST_READ) && lastCyc) || (state == ST_WEND);
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 8,
  parameter int CLK_NS     = 4,
  parameter int RD_CYC_NS  = 10,
  parameter int ADDR_AC_NS = 10,
  parameter int CE_AC_NS   = 10,
  parameter int OE_REL_NS  = 4,
  parameter int WR_CYC_NS  = 10,
  parameter int WE_PW_NS   = 8,
  parameter int ADDR_WE_NS = 8,
  parameter int CE_WE_NS   = 8,
  parameter int DSETUP_NS  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  localparam int RD_CYC = maxOf(1, maxOf(cyclesFor(RD_CYC_NS, CLK_NS),
                          maxOf(cyclesFor(ADDR_AC_NS, CLK_NS), cyclesFor(CE_AC_NS, CLK_NS))));
  localparam int TURN_CYC   = maxOf(1, cyclesFor(OE_REL_NS, CLK_NS));
  localparam int PULSE_BASE = maxOf(maxOf(cyclesFor(WE_PW_NS, CLK_NS), cyclesFor(ADDR_WE_NS, CLK_NS)),
                                    maxOf(cyclesFor(CE_WE_NS, CLK_NS), cyclesFor(DSETUP_NS, CLK_NS)));
  // the whole write window (turn + pulse + end cycle) must also cover the write cycle time
  localparam int WC_LEFT    = cyclesFor(WR_CYC_NS, CLK_NS) - TURN_CYC - 1;
  localparam int PULSE_CYC  = maxOf(1, maxOf(PULSE_BASE, WC_LEFT));
  localparam int CNT_W      = maxOf(1, $clog2(maxOf(RD_CYC, maxOf(TURN_CYC, PULSE_CYC)) + 1));

  dpStrobe_t strobe;

  asram_seq #(
    .RD_CYC   (RD_CYC),
    .TURN_CYC (TURN_CYC),
    .PULSE_CYC(PULSE_CYC),
    .CNT_W    (CNT_W)
  ) u_seq (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .reqReady(reqReady),
    .strobe  (strobe),
    .memCeN  (memCeN),
    .memOeN  (memOeN),
    .memWeN  (memWeN),
    .memDqOe (memDqOe),
    .rspValid(rspValid)
  );

  asram_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .memDqIn (memDqIn),
    .memAddr (memAddr),
    .memDqOut(memDqOut),
    .rspRdata(rspRdata)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic              memCeN,
  input logic              memOeN,
  input logic              memWeN,
  input logic              memDqOe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memDqOut
);

  p_idle_deselect_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN && memOeN && memWeN && !memDqOe));

  p_read_strobes_r3: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memWeN && !memCeN && !memDqOe));

  p_rsp_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  p_write_oe_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memOeN && !memCeN));

  p_no_drive_with_oe_r5: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOeN);

  p_drive_covers_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memDqOe);

  p_release_after_we_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memDqOe) |-> ($past(memWeN) && memCeN && rspValid));

  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (memDqOe && $past(memDqOe)) |-> $stable(memDqOut));

endmodule

bind asram_ctrl asram_ctrl_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .reqReady(reqReady),
  .rspValid(rspValid),
  .memCeN  (memCeN),
  .memOeN  (memOeN),
  .memWeN  (memWeN),
  .memDqOe (memDqOe),
  .memAddr (memAddr),
  .memDqOut(memDqOut)
);

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;

  localparam int AW = 20;
  localparam int DW = 8;
  // R8: CLK_NS = 4 -> read 10 ns = 3 cycles, release 4 ns = 1, pulse 8 ns = 2
  localparam int EXP_RD    = 3;
  localparam int EXP_TURN  = 1;
  localparam int EXP_PULSE = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          reqReady, rspValid;
  logic [DW-1:0] rspRdata;
  logic [AW-1:0] memAddr;
  logic          memCeN, memOeN, memWeN, memDqOe;
  logic [DW-1:0] memDqOut, memDqIn;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  asram_ctrl uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspRdata(rspRdata), .memAddr(memAddr),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // memory model: drives only in the read combination, commits when CE/WE overlap ends
  logic [DW-1:0] ramArr [int];
  logic [DW-1:0] refArr [int];

  function automatic logic [DW-1:0] fillOf(input logic [AW-1:0] a);
    return ~a[DW-1:0];
  endfunction

  always_comb begin
    if (!memCeN && !memOeN && memWeN)
      memDqIn = ramArr.exists(int'(memAddr)) ? ramArr[int'(memAddr)] : fillOf(memAddr);
    else
      memDqIn = 8'h00;
  end

  // scoreboard queue: {isWrite, expected data}
  typedef struct { bit isWrite; logic [DW-1:0] data; } expItem_t;
  expItem_t expQ[$];

  logic [AW-1:0] curAddr = '0;
  logic [DW-1:0] curData = '0;

  task automatic doReq(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    expItem_t it;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqAddr = a; reqWdata = d;
    curAddr = a; curData = d;
    it.isWrite = w;
    if (w) begin
      refArr[int'(a)] = d;
      it.data = d;
    end else begin
      it.data = refArr.exists(int'(a)) ? refArr[int'(a)] : fillOf(a);
    end
    expQ.push_back(it);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // monitor: responses (R4, R10) and pin timing (R3, R5, R6, R7, R9)
  logic          pCeN = 1, pOeN = 1, pWeN = 1, pOe = 0, pOv = 0;
  logic [AW-1:0] pAddr = '0;
  logic [DW-1:0] pDq = '0;
  int            ceRun = 0, oeRun = 0, weRun = 0;
  bit            badAddr = 0, badData = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (rspValid) begin
        if (expQ.size() == 0) begin
          check(0, "R2/R10 unexpected response", 1, 0);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          if (!it.isWrite) check(rspRdata == it.data, "R10 read data", rspRdata, it.data);
        end
      end
      // commit on end of overlap
      if (pOv && !(!memCeN && !memWeN)) ramArr[int'(pAddr)] = pDq;
      if (!memCeN) begin
        ceRun++;
        if (memAddr != curAddr) badAddr = 1;
      end
      if (!memOeN) oeRun++;
      if (!memWeN) begin
        weRun++;
        if (memDqOut != curData) badData = 1;
      end
      if (memOeN && !pOeN) begin
        check(oeRun == EXP_RD, "R3/R8 read strobe length", oeRun, EXP_RD);
        check(rspValid, "R4 response with output-enable rise", rspValid, 1);
        oeRun = 0;
      end
      if (memDqOe && !pOe)
        check(ceRun == EXP_TURN + 1 && memOeN, "R5/R8 turnaround before drive", ceRun, EXP_TURN + 1);
      if (memWeN && !pWeN) begin
        check(weRun == EXP_PULSE, "R6/R8 write pulse length", weRun, EXP_PULSE);
        check(memDqOe && !memCeN, "R7 drive held after write-enable rise", memDqOe, 1);
        check(!badData, "R6 write data on bus", badData, 0);
        weRun = 0; badData = 0;
      end
      if (!memDqOe && pOe)
        check(pWeN && memCeN && rspValid, "R7 release with deselect", {pWeN, memCeN, rspValid}, 3'b111);
      if (memCeN && !pCeN) begin
        check(!badAddr, "R9 address held", badAddr, 0);
        badAddr = 0; ceRun = 0;
      end
    end
    pOv = !memCeN && !memWeN; pAddr = memAddr; pDq = memDqOut;
    pCeN = memCeN; pOeN = memOeN; pWeN = memWeN; pOe = memDqOe;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R10 watchdog expired", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(memCeN && memOeN && memWeN, "R1 strobes high in reset", {memCeN, memOeN, memWeN}, 3'b111);
    check(!memDqOe && reqReady, "R1 drivers off, ready", {memDqOe, reqReady}, 2'b01);
    rstN = 1'b1;
    @(negedge clk);
    check(memCeN && !memDqOe && reqReady, "R1 idle after reset", {memCeN, memDqOe, reqReady}, 3'b101);

    // writes with varied patterns and edge addresses
    doReq(1, 20'h00000, 8'h00);
    doReq(1, 20'hFFFFF, 8'hFF);
    doReq(1, 20'h5A5A5, 8'h5A);
    doReq(1, 20'h12345, 8'hA5);
    // reads back, plus an unwritten address
    doReq(0, 20'hFFFFF, 8'h00);
    doReq(0, 20'h00000, 8'h00);
    doReq(0, 20'h12345, 8'h00);
    doReq(0, 20'h5A5A5, 8'h00);
    doReq(0, 20'h00777, 8'h00);
    // alternating write/read on one address, overwrite (R10 ordering)
    for (int i = 0; i < 6; i++) begin
      doReq(1, 20'h0ABCD, 8'(8'h11 * i + 3));
      doReq(0, 20'h0ABCD, 8'h00);
    end

    // R2: reqValid held during a busy read is ignored
    begin
      expItem_t it;
      @(negedge clk);
      while (!reqReady) @(negedge clk);
      reqValid = 1; reqWrite = 0; reqAddr = 20'hFFFFF; curAddr = 20'hFFFFF;
      it.isWrite = 0; it.data = 8'hFF; expQ.push_back(it);
      @(negedge clk);
      check(!reqReady, "R2 not ready while busy", reqReady, 0);
      reqWrite = 1; reqAddr = 20'h00ABC; reqWdata = 8'h3C;
      @(negedge clk);
      check(memAddr == 20'hFFFFF, "R2 address unchanged by busy request", memAddr, 20'hFFFFF);
      reqValid = 0;
    end
    doReq(0, 20'h00ABC, 8'h00);   // must still be the fill value: not written (R2)

    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R10 every request answered", expQ.size(), 0);
    check(memCeN && reqReady, "R1 back to standby", {memCeN, reqReady}, 2'b11);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule